// File: doc/BRIEF.md
# Memory Barrier Sync Controller

This block sits in the issue path of a load/store unit and enforces memory ordering around barrier operations. Upstream presents an in-order stream of operations. Each operation is a load, a store, or a barrier, and a barrier carries a 5-bit barrier-type code. The memory side returns two kinds of single-cycle pulses. An ordering pulse says that one older operation has passed the point after which it can no longer be reordered. An acknowledge pulse says that one older operation has been globally performed.

The block keeps two occupancy counters for issued loads and stores. One counts operations that have not yet passed the ordering point. The other counts operations that have not yet been acknowledged. When a barrier is accepted, the block raises its issue stall and holds every younger operation, including a further barrier, until the selected condition is met. A completion barrier waits for the acknowledge count to reach zero. The lighter ordering barrier waits only for the ordering count to reach zero. Any type code that is not implemented is treated as a completion barrier.

Retirement is reported by a one-cycle done pulse together with the mode that retired. Instruction fetch is never affected by this block.

Top module: `mbsync_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `issue_stall` and `barrier_done` are low, both counters are empty, and a barrier accepted right after reset retires with no wait.
- R2: An operation is accepted in a cycle where `op_valid` is high and `issue_stall` is low. An accepted load (`op_kind`=1) or store (`op_kind`=2) adds one to both outstanding counts. A barrier (`op_kind`=3) adds to neither.
- R3: A barrier with type code 0x00 is a completion barrier. It does not retire until every older load and store has been acknowledged, even after all of them have passed the ordering point.
- R4: A barrier with type code 0x10 is an ordering barrier. It retires once every older load and store has passed the ordering point, whether or not any acknowledges have arrived, and it reports `done_mode`=1.
- R5: Every type code other than 0x10 retires under the completion condition and reports `done_mode`=0.
- R6: From the cycle after a barrier is accepted until it retires, `issue_stall` is high and no operation is accepted.
- R7: `barrier_done` is high for exactly one cycle. It is first visible one clock edge after the edge at which the required count becomes zero, or one edge after acceptance if the count is already zero. `issue_stall` is low in that same cycle, unless the acknowledge count is at capacity.
- R8: A second barrier held at the input while one is pending is accepted in the cycle the first retires, and it retires on its own condition afterwards.
- R9: While the acknowledge count equals `MAX_OUT`, `issue_stall` is high. One acknowledge lowers the stall in the following cycle.
- R10: An ordering pulse or acknowledge pulse that arrives while its counter is zero is ignored. It cannot retire a later barrier early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented; held until accepted |
| op_kind | input | 2 | 0 none, 1 load, 2 store, 3 barrier |
| op_btype | input | 5 | Barrier type code, used when op_kind is 3 |
| ord_pass | input | 1 | Pulse: one older operation passed the ordering point |
| gbl_ack | input | 1 | Pulse: one older operation was globally performed |
| issue_stall | output | 1 | Registered; no operation is accepted while high |
| barrier_done | output | 1 | Registered one-cycle pulse when a barrier retires |
| done_mode | output | 1 | Mode of the retired barrier: 1 ordering, 0 completion |

## Verification
The hardest condition to create is the window in which an ordering barrier and a completion barrier must behave differently. Older operations have all passed the ordering point, but none has yet been acknowledged. The bench opens this window on purpose: it issues up to three operations, then the barrier, then delivers every ordering pulse before any acknowledge. It does this for every one of the 32 type codes and checks the exact cycle of retirement. A second held barrier, stray pulses on empty counters, and a capacity fill are driven as separate sequences.

// File: rtl/mbs_pkg.sv
`timescale 1ns/1ps
package mbs_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_STORE = 2'd2,
    OP_SYNC  = 2'd3
  } op_kind_t;

  typedef enum logic {
    BAR_COMPLETE = 1'b0,
    BAR_ORDER    = 1'b1
  } bar_mode_t;

  localparam logic [4:0] BT_ORDER_CODE = 5'h10;
endpackage

// File: rtl/mbs_type_decode.sv
`timescale 1ns/1ps
module mbs_type_decode
  import mbs_pkg::*;
#(
  parameter bit ORDER_EN = 1'b1
) (
  input  logic [4:0] btype,
  output bar_mode_t  mode
);
  // Only the ordering code selects the light barrier; every other code,
  // implemented or not, falls back to the full completion barrier.
  logic is_order_code;
  assign is_order_code = (btype == BT_ORDER_CODE);

  always_comb begin
    if (ORDER_EN && is_order_code) mode = BAR_ORDER;
    else                           mode = BAR_COMPLETE;
  end
endmodule

// File: rtl/mbs_out_counter.sv
`timescale 1ns/1ps
module mbs_out_counter #(
  parameter int MAX_CNT = 16,
  localparam int W = $clog2(MAX_CNT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_d,
  output logic         zero
);
  localparam logic [W-1:0] MAXV = W'(MAX_CNT);

  logic inc_ok, dec_ok;
  assign inc_ok = inc && (cnt_q != MAXV);
  assign dec_ok = dec && (cnt_q != '0);   // stray pulses on empty are dropped

  always_comb begin
    cnt_d = cnt_q;
    unique case ({inc_ok, dec_ok})
      2'b10:   cnt_d = cnt_q + W'(1);
      2'b01:   cnt_d = cnt_q - W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/mbs_barrier_fsm.sv
`timescale 1ns/1ps
module mbs_barrier_fsm
  import mbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sync_acc,
  input  bar_mode_t mode_in,
  input  logic      ord_zero,
  input  logic      gbl_zero,
  output logic      pend_q,
  output logic      pend_d,
  output logic      done_q,
  output logic      done_mode_q
);
  bar_mode_t mode_q;
  logic      req_zero;
  logic      retire;

  // Retirement condition depends on the latched mode of the pending barrier.
  assign req_zero = (mode_q == BAR_ORDER) ? ord_zero : gbl_zero;
  assign retire   = pend_q && req_zero;

  always_comb begin
    pend_d = pend_q;
    if (retire)   pend_d = 1'b0;
    if (sync_acc) pend_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      mode_q      <= BAR_COMPLETE;
      done_q      <= 1'b0;
      done_mode_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      done_q <= retire;
      if (sync_acc) mode_q      <= mode_in;
      if (retire)   done_mode_q <= (mode_q == BAR_ORDER);
    end
  end
endmodule

// File: rtl/mbsync_ctrl.sv
`timescale 1ns/1ps
module mbsync_ctrl
  import mbs_pkg::*;
#(
  parameter int MAX_OUT  = 16,
  parameter bit ORDER_EN = 1'b1,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  logic [1:0] op_kind,
  input  logic [4:0] op_btype,
  input  logic       ord_pass,
  input  logic       gbl_ack,
  output logic       issue_stall,
  output logic       barrier_done,
  output logic       done_mode
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_OUT);

  logic             stall_q;
  logic             accept, mem_acc, sync_acc;
  logic [CNT_W-1:0] ord_cnt, ord_cnt_d;
  logic [CNT_W-1:0] gbl_cnt, gbl_cnt_d;
  logic             ord_zero, gbl_zero;
  bar_mode_t        dec_mode;
  logic             pend_q, pend_d;

  // Acceptance is gated by the registered stall, so once a barrier is in,
  // nothing younger can be counted against it.
  assign accept   = op_valid && !stall_q;
  assign mem_acc  = accept && ((op_kind == OP_LOAD) || (op_kind == OP_STORE));
  assign sync_acc = accept && (op_kind == OP_SYNC);

  mbs_type_decode #(.ORDER_EN(ORDER_EN)) u_dec (
    .btype (op_btype),
    .mode  (dec_mode)
  );

  mbs_out_counter #(.MAX_CNT(MAX_OUT)) u_ord_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (mem_acc),
    .dec   (ord_pass),
    .cnt_q (ord_cnt),
    .cnt_d (ord_cnt_d),
    .zero  (ord_zero)
  );

  mbs_out_counter #(.MAX_CNT(MAX_OUT)) u_gbl_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (mem_acc),
    .dec   (gbl_ack),
    .cnt_q (gbl_cnt),
    .cnt_d (gbl_cnt_d),
    .zero  (gbl_zero)
  );

  mbs_barrier_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .sync_acc    (sync_acc),
    .mode_in     (dec_mode),
    .ord_zero    (ord_zero),
    .gbl_zero    (gbl_zero),
    .pend_q      (pend_q),
    .pend_d      (pend_d),
    .done_q      (barrier_done),
    .done_mode_q (done_mode)
  );

  // Stall is registered from next-state values so it is valid in the
  // first cycle of a pending barrier or a full acknowledge counter.
  always_ff @(posedge clk) begin
    if (rst) stall_q <= 1'b0;
    else     stall_q <= pend_d || (gbl_cnt_d == CAP);
  end

  assign issue_stall = stall_q;

  logic unused_ok;
  assign unused_ok = ^{ord_cnt_d, pend_q};
endmodule

// File: rtl/mbsync_ctrl_chk.sv
`timescale 1ns/1ps
module mbsync_ctrl_chk #(
  parameter int MAX_OUT = 16,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic [1:0]       op_kind,
  input logic             issue_stall,
  input logic             barrier_done,
  input logic             done_mode,
  input logic [CNT_W-1:0] ord_cnt,
  input logic [CNT_W-1:0] gbl_cnt
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!issue_stall && !barrier_done));

  assert_compl_retire_R3: assert property (@(posedge clk) disable iff (rst)
    (barrier_done && !done_mode) |-> ($past(gbl_cnt) == '0));

  assert_order_retire_R4: assert property (@(posedge clk) disable iff (rst)
    (barrier_done && done_mode) |-> ($past(ord_cnt) == '0));

  assert_sync_stalls_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_kind == 2'd3) && !issue_stall) |=> issue_stall);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    barrier_done |=> !barrier_done);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    gbl_cnt <= CNT_W'(MAX_OUT));

  assert_full_stalls_R9: assert property (@(posedge clk) disable iff (rst)
    (gbl_cnt == CNT_W'(MAX_OUT)) |-> issue_stall);
endmodule

bind mbsync_ctrl mbsync_ctrl_chk #(.MAX_OUT(MAX_OUT)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .op_valid     (op_valid),
  .op_kind      (op_kind),
  .issue_stall  (issue_stall),
  .barrier_done (barrier_done),
  .done_mode    (done_mode),
  .ord_cnt      (ord_cnt),
  .gbl_cnt      (gbl_cnt)
);

// File: tb/mbsync_ctrl_bench.sv
`timescale 1ns/1ps
module mbsync_ctrl_bench;
  import mbs_pkg::*;
  localparam int MAXO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic op_valid = 1'b0;
  logic [1:0] op_kind = 2'd0;
  logic [4:0] op_btype = 5'd0;
  logic ord_pass = 1'b0;
  logic gbl_ack = 1'b0;
  logic issue_stall, barrier_done, done_mode;

  int nchk = 0;
  int nerr = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mbsync_ctrl #(.MAX_OUT(MAXO), .ORDER_EN(1'b1)) u_mbsync_ctrl (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .op_btype(op_btype), .ord_pass(ord_pass), .gbl_ack(gbl_ack),
    .issue_stall(issue_stall), .barrier_done(barrier_done), .done_mode(done_mode)
  );

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic issue(logic [1:0] k, logic [4:0] b);
    op_valid = 1'b1; op_kind = k; op_btype = b;
    cyc();
    op_valid = 1'b0; op_kind = 2'd0;
  endtask

  task automatic p_ord();
    ord_pass = 1'b1; cyc(); ord_pass = 1'b0;
  endtask

  task automatic p_ack();
    gbl_ack = 1'b1; cyc(); gbl_ack = 1'b0;
  endtask

  // n older ops, barrier of type bt, all ordering pulses before any ack.
  task automatic run(int bt, int n);
    bit    is_ord = (bt == 16);
    string rq = is_ord ? "R4" : ((bt == 0) ? "R3" : "R5");
    for (int i = 0; i < n; i++) begin
      issue((i % 2) ? OP_STORE : OP_LOAD, 5'd0);
      chk("R2 accepting", int'(issue_stall), 0);
    end
    issue(OP_SYNC, 5'(bt));
    chk("R6 stall after barrier", int'(issue_stall), 1);
    chk({rq, " no early done"}, int'(barrier_done), 0);
    for (int i = 0; i < n; i++) begin
      p_ord();
      chk({rq, " done during ordering phase"}, int'(barrier_done), 0);
    end
    if (!is_ord) begin
      if (n > 0) begin
        for (int i = 0; i < 3; i++) begin
          cyc();
          chk({rq, " waits for acks"}, int'(barrier_done), 0);
          chk("R6 stall held", int'(issue_stall), 1);
        end
      end
      for (int i = 0; i < n; i++) begin
        p_ack();
        chk({rq, " done before last ack"}, int'(barrier_done), 0);
      end
    end
    cyc();
    chk({rq, " R7 done pulse"}, int'(barrier_done), 1);
    chk({rq, " done_mode"}, int'(done_mode), int'(is_ord));
    chk("R7 stall released", int'(issue_stall), 0);
    cyc();
    chk("R7 single cycle", int'(barrier_done), 0);
    if (is_ord) for (int i = 0; i < n; i++) p_ack();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin : main
    repeat (3) cyc();
    rst = 1'b0;
    #0;
    chk("R1 stall after reset", int'(issue_stall), 0);
    chk("R1 done after reset", int'(barrier_done), 0);
    // R1: empty counters -> immediate retire
    issue(OP_SYNC, 5'h00);
    cyc();
    chk("R1 immediate retire", int'(barrier_done), 1);
    cyc();

    // Sweep all type codes with 0..3 older operations (R3 R4 R5)
    for (int bt = 0; bt < 32; bt++)
      for (int n = 0; n < 4; n++)
        run(bt, n);

    // R10: stray pulses on empty counters
    for (int i = 0; i < 3; i++) begin p_ord(); p_ack(); end
    issue(OP_LOAD, 5'd0);
    issue(OP_SYNC, 5'h10);
    repeat (3) begin
      cyc();
      chk("R10 stray pulses ignored", int'(barrier_done), 0);
    end
    p_ord();
    cyc();
    chk("R10 retire after real pulse", int'(barrier_done), 1);
    p_ack();

    // R8: second barrier held while first is pending
    issue(OP_STORE, 5'd0);
    issue(OP_SYNC, 5'h00);
    op_valid = 1'b1; op_kind = OP_SYNC; op_btype = 5'h10;
    p_ord();
    cyc();
    chk("R8 first still pending", int'(barrier_done), 0);
    p_ack();                       // edge E: gbl count -> 0
    cyc();                         // E+1: first retires, stall low
    chk("R8 first done", int'(barrier_done), 1);
    chk("R8 first mode", int'(done_mode), 0);
    cyc();                         // E+2: held barrier accepted
    op_valid = 1'b0; op_kind = 2'd0;
    chk("R8 second pending", int'(issue_stall), 1);
    chk("R8 no done yet", int'(barrier_done), 0);
    cyc();                         // E+3
    chk("R8 second done", int'(barrier_done), 1);
    chk("R8 second mode", int'(done_mode), 1);
    cyc();

    // R9: fill the acknowledge counter
    for (int i = 0; i < MAXO; i++) issue(OP_LOAD, 5'd0);
    chk("R9 stall at capacity", int'(issue_stall), 1);
    p_ord();
    cyc();
    chk("R9 still full without ack", int'(issue_stall), 1);
    p_ack();
    chk("R9 stall released by ack", int'(issue_stall), 0);
    for (int i = 1; i < MAXO; i++) begin p_ord(); p_ack(); end
    issue(OP_SYNC, 5'h00);
    cyc();
    chk("R9 drained counters", int'(barrier_done), 1);
    cyc();

    // R1: reset mid-barrier clears pending state
    issue(OP_LOAD, 5'd0);
    issue(OP_SYNC, 5'h00);
    rst = 1'b1; cyc(); rst = 1'b0;
    chk("R1 reset clears stall", int'(issue_stall), 0);
    issue(OP_SYNC, 5'h00);
    cyc();
    chk("R1 reset clears counts", int'(barrier_done), 1);
    cyc();

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule